// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Controller

This block watches a bank of 23 general purpose input pins and turns chosen edges on them into interrupt events. Each pin is brought into the clock domain through a two-flop synchronizer. It is then compared with its value one cycle earlier, so that a rising or a falling transition can be detected. The pin's polarity bit picks which of the two counts. An event is recorded only on a pin that is armed: interrupt enabled, switched to GPIO use and set as an input. The event stays latched in a per-pin status bit until software clears it.

A single summary bit collects all pin events and drives a level-high interrupt line. It is sticky and separate from the per-pin status. Emptying the status register does not drop the summary bit; only its own clear write does that. If pin events are still pending when the summary bit is cleared, it comes back one cycle later. Software reaches the configuration, clear, status and summary registers over a simple single-cycle register bus.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset every configuration register, the status register and the summary bit read 0, and `irq_o` is low.
- R2: The status register (offset 5) is read-only: a bus write to offset 5 leaves its contents unchanged.
- R3: A pin's status bit can set only while that pin's enable bit (offset 0), mode bit (offset 1, 1 = GPIO) and direction bit (offset 2, 1 = input) are all 1. With any one of them at 0, edges on the pin are not recorded.
- R4: Polarity bit (offset 3) 0 records a 0-to-1 transition and 1 records a 1-to-0 transition. The other transition and a steady level record nothing.
- R5: Writing 1 to bit n of the clear register (offset 4) clears status bit n. Bits written 0 leave their status bits unchanged.
- R6: Whenever a status bit is set, the summary bit (offset 6, bit 0) becomes 1, and `irq_o` equals the summary bit.
- R7: Clearing every status bit leaves the summary bit at 1.
- R8: Writing 1 to bit 0 at offset 6 clears the summary bit; writing 0 there has no effect.
- R9: If any status bit is 1 when the summary bit is cleared, the summary bit reads 0 for exactly one cycle and is 1 again on the next.
- R10: When a recorded edge and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R11: Register bits above pin 22 read 0 at every offset, the clear register always reads 0, and pin 22 is handled like every other pin.
- R12: A pin change made before clock edge k shows in the status register after edge k+2 and in the summary bit and `irq_o` after edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 23 | Asynchronous GPIO pin levels |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register offset (0 enable, 1 mode, 2 direction, 3 polarity, 4 clear, 5 status, 6 summary) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level-high interrupt, equal to the summary bit |

## Verification
A status bit that fails to latch, latches while disarmed, or drops without a clear write shows up in the status read-back within three cycles of the pin change. It is also seen as a missing or spurious rise of `irq_o` one cycle after that. A summary bit wrongly tied to the status contents shows in two places. It falls as soon as the last status bit is cleared, or it stays low one cycle too long after a clear made while events are pending; both are visible on `irq_o` within a cycle. A wrong priority between a recorded edge and a clear leaves the status bit at 0 after a clear write that was timed to meet the edge.

// File: rtl/gpio_evt_pkg.sv
// Package gpio_evt_pkg
// Shared constants and the register offset encoding of the GPIO edge
// interrupt controller. Assumes a 32-bit register bus with word offsets.
package gpio_evt_pkg;

    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 3;

    // Register offsets on the bus
    typedef enum logic [BUS_AW-1:0] {
        OFS_ENABLE = 3'd0,
        OFS_MODE   = 3'd1,
        OFS_DIR    = 3'd2,
        OFS_POLAR  = 3'd3,
        OFS_CLEAR  = 3'd4,
        OFS_STATUS = 3'd5,
        OFS_SUMM   = 3'd6
    } reg_ofs_e;

    // Bit of the summary register that holds the summary flag
    localparam int unsigned SUMM_BIT = 0;

endpackage

// File: rtl/gpio_evt_sync.sv
// Module gpio_evt_sync
// Brings a vector of asynchronous pin levels into the clock domain through
// a chain of STAGES flops per bit. Assumes every pin is an independent
// level; no relation between bits is kept.
module gpio_evt_sync #(
    parameter int unsigned WIDTH  = 23,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture raw pin levels
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_next
                // shift through the remaining stages
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_status.sv
// Module gpio_evt_status
// Edge detector and sticky status register. Compares synchronized pin
// levels with the previous cycle, keeps the transition chosen by each
// polarity bit (0 rising, 1 falling), gates it with the arming mask and
// latches it. A clear mask drops bits, but a new event in the same cycle
// wins. Assumes sync_i is already in the clock domain.
module gpio_evt_status #(
    parameter int unsigned WIDTH = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] polar_i,
    input  logic [WIDTH-1:0] armed_i,
    input  logic [WIDTH-1:0] clr_mask_i,
    output logic [WIDTH-1:0] set_o,
    output logic [WIDTH-1:0] stat_o
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] stat_q;
    logic [WIDTH-1:0] hit;

    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            // pick the transition this pin's polarity asks for
            always_comb begin
                if (polar_i[p]) hit[p] = prev_q[p] & ~sync_i[p];
                else            hit[p] = sync_i[p] & ~prev_q[p];
            end
        end
    endgenerate

    assign set_o = hit & armed_i;

    // remember last synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    // sticky status: new events set, clear mask drops, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= set_o | (stat_q & ~clr_mask_i);
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/gpio_evt_summary.sv
// Module gpio_evt_summary
// Sticky summary flag. Sets on any pending status bit, clears only on
// its own clear strobe; the clear takes effect for one cycle, after which
// pending status sets it again. Assumes clr_i is a one-cycle strobe.
module gpio_evt_summary (
    input  logic clk,
    input  logic rst_n,
    input  logic any_stat_i,
    input  logic clr_i,
    output logic summ_o
);

    logic summ_q;

    // explicit clear wins for one cycle, else accumulate pending status
    always_ff @(posedge clk) begin
        if (!rst_n)     summ_q <= 1'b0;
        else if (clr_i) summ_q <= 1'b0;
        else            summ_q <= summ_q | any_stat_i;
    end

    assign summ_o = summ_q;

endmodule

// File: rtl/gpio_evt_regs.sv
// Module gpio_evt_regs
// Register bank on a single-cycle bus: four configuration registers, a
// write-one-to-clear strobe for status, a read-only status view and the
// summary flag with its own write-one-to-clear. Reads are combinational.
// Assumes bus_wr is high for exactly one cycle per write.
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int unsigned WIDTH = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [WIDTH-1:0]  stat_i,
    input  logic              summ_i,
    output logic [WIDTH-1:0]  enable_o,
    output logic [WIDTH-1:0]  mode_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  polar_o,
    output logic [WIDTH-1:0]  clr_mask_o,
    output logic              summ_clr_o
);

    localparam int unsigned PAD = BUS_DW - WIDTH;

    logic [WIDTH-1:0] enable_q, mode_q, dir_q, polar_q;
    logic [WIDTH-1:0] wfield;
    logic             unused_wdata_hi;

    assign wfield          = bus_wdata[WIDTH-1:0];
    assign unused_wdata_hi = ^bus_wdata[BUS_DW-1:WIDTH];

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            mode_q   <= '0;
            dir_q    <= '0;
            polar_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_ENABLE: enable_q <= wfield;
                OFS_MODE:   mode_q   <= wfield;
                OFS_DIR:    dir_q    <= wfield;
                OFS_POLAR:  polar_q  <= wfield;
                default:    ;
            endcase
        end
    end

    // one-cycle clear strobes toward status and summary
    always_comb begin
        clr_mask_o = '0;
        summ_clr_o = 1'b0;
        if (bus_wr && bus_addr == OFS_CLEAR) clr_mask_o = wfield;
        if (bus_wr && bus_addr == OFS_SUMM)  summ_clr_o = bus_wdata[SUMM_BIT];
    end

    // read-back multiplexer, unused bits read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ENABLE: bus_rdata = {{PAD{1'b0}}, enable_q};
            OFS_MODE:   bus_rdata = {{PAD{1'b0}}, mode_q};
            OFS_DIR:    bus_rdata = {{PAD{1'b0}}, dir_q};
            OFS_POLAR:  bus_rdata = {{PAD{1'b0}}, polar_q};
            OFS_STATUS: bus_rdata = {{PAD{1'b0}}, stat_i};
            OFS_SUMM:   bus_rdata[SUMM_BIT] = summ_i;
            default:    bus_rdata = '0;
        endcase
    end

    assign enable_o = enable_q;
    assign mode_o   = mode_q;
    assign dir_o    = dir_q;
    assign polar_o  = polar_q;

endmodule

// File: rtl/gpio_evt_irq.sv
// Module gpio_evt_irq
// Top of the GPIO edge interrupt controller: synchronizer, edge detector
// with sticky status, sticky summary flag and register bank. Assumes
// pin_i may change at any time and the bus is driven synchronously.
module gpio_evt_irq
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS       = 23,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq_o
);

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] enable, mode, dir, polar;
    logic [NPINS-1:0] armed;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] stat_q;
    logic             summ_clr;
    logic             summ_q;

    gpio_evt_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    assign armed = enable & mode & dir;

    gpio_evt_status #(.WIDTH(NPINS)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (pin_sync),
        .polar_i    (polar),
        .armed_i    (armed),
        .clr_mask_i (clr_mask),
        .set_o      (set_vec),
        .stat_o     (stat_q)
    );

    gpio_evt_summary u_summary (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_stat_i (|stat_q),
        .clr_i      (summ_clr),
        .summ_o     (summ_q)
    );

    gpio_evt_regs #(.WIDTH(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .stat_i     (stat_q),
        .summ_i     (summ_q),
        .enable_o   (enable),
        .mode_o     (mode),
        .dir_o      (dir),
        .polar_o    (polar),
        .clr_mask_o (clr_mask),
        .summ_clr_o (summ_clr)
    );

    assign irq_o = summ_q;

endmodule

// File: rtl/gpio_evt_irq_chk.sv
// Module gpio_evt_irq_chk
// Property checker bound to gpio_evt_irq. Observes status, summary,
// arming and clear strobes; drives nothing.
module gpio_evt_irq_chk #(
    parameter int unsigned NPINS = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] set_vec,
    input logic [NPINS-1:0] armed,
    input logic [NPINS-1:0] clr_mask,
    input logic             summ_q,
    input logic             summ_clr,
    input logic [31:0]      bus_rdata
);

    // R3
    status_needs_arming_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(armed)) == '0));

    // R5
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~$past(clr_mask) & ~stat_q) == '0));

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    // R6
    summary_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q != '0) && !summ_clr) |=> summ_q);

    // R7
    summary_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (summ_q && !summ_clr) |=> summ_q);

    // R9
    summary_reasserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (summ_clr && (stat_q != '0)) |=> !summ_q ##1 summ_q);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:NPINS] == '0);

endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_q    (stat_q),
    .set_vec   (set_vec),
    .armed     (armed),
    .clr_mask  (clr_mask),
    .summ_q    (summ_q),
    .summ_clr  (summ_clr),
    .bus_rdata (bus_rdata)
);

// File: tb/test_gpio_evt_irq.sv
// Scoreboard bench: driver tasks queue expected read values, a monitor
// pops them and compares against the bus and irq_o.
module test_gpio_evt_irq;

    localparam int NP = 23;
    localparam logic [2:0] A_EN = 3'd0, A_MODE = 3'd1, A_DIR = 3'd2, A_POL = 3'd3,
                           A_CLR = 3'd4, A_STAT = 3'd5, A_SUMM = 3'd6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp_data;
        logic        chk_data;
        logic        exp_irq;
        logic        chk_irq;
        string       tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    gpio_evt_irq i_gpio_evt_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // monitor: compare queued expectations 2 ns after each falling edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                if (it.chk_data) begin
                    checks++;
                    if (bus_rdata !== it.exp_data) begin
                        errors++;
                        $display("FAIL %s data: actual %h expected %h", it.tag, bus_rdata, it.exp_data);
                    end
                end
                if (it.chk_irq) begin
                    checks++;
                    if (irq_o !== it.exp_irq) begin
                        errors++;
                        $display("FAIL %s irq: actual %b expected %b", it.tag, irq_o, it.exp_irq);
                    end
                end
            end
        end
    end

    task automatic push(input logic [31:0] d, input logic cd, input logic i, input logic ci, input string tag);
        item_t it;
        it.exp_data = d; it.chk_data = cd; it.exp_irq = i; it.chk_irq = ci; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        push(d, 1'b1, 1'b0, 1'b0, tag);
    endtask

    task automatic rd_irq(input logic [2:0] a, input logic [31:0] d, input logic i, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        push(d, 1'b1, i, 1'b1, tag);
    endtask

    task automatic irq_now(input logic i, input string tag);
        push('0, 1'b0, i, 1'b1, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] b(input int p);
        return 32'h1 << p;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] armed_m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_irq(A_STAT, 32'h0, 1'b0, "R1 status");
        rd(A_SUMM, 32'h0, "R1 summary");
        rd(A_EN, 32'h0, "R1 enable");
        rd(A_POL, 32'h0, "R1 polarity");

        // R11 width masking and clear read-back
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, 32'h007F_FFFF, "R11 enable width");
        wr(A_EN, 32'h0);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_CLR, 32'h0, "R11 clear reads zero");

        // R3 arming: direction output, then mode not GPIO
        wr(A_EN, b(7)); wr(A_MODE, b(7)); wr(A_DIR, 32'h0);
        set_pin(7, 1'b1); settle();
        rd(A_STAT, 32'h0, "R3 direction output");
        set_pin(7, 1'b0); settle();
        wr(A_MODE, 32'h0); wr(A_DIR, b(7));
        set_pin(7, 1'b1); settle();
        rd_irq(A_STAT, 32'h0, 1'b0, "R3 mode not gpio");

        // arm pins 3, 5, 9, 22; pin 5 falling
        armed_m = b(3) | b(5) | b(9) | b(22);
        wr(A_EN, armed_m); wr(A_MODE, armed_m); wr(A_DIR, armed_m); wr(A_POL, b(5));

        // R12 latency of a rising edge on pin 3
        set_pin(3, 1'b1);
        rd(A_STAT, 32'h0, "R12 after edge k");
        rd(A_STAT, 32'h0, "R12 after edge k+1");
        rd_irq(A_STAT, b(3), 1'b0, "R12 after edge k+2");
        rd_irq(A_SUMM, 32'h1, 1'b1, "R6 summary and irq");

        // R4 falling polarity on pin 5
        set_pin(5, 1'b1); settle();
        rd(A_STAT, b(3), "R4 rising ignored on falling pin");
        set_pin(5, 1'b0); settle();
        rd(A_STAT, b(3) | b(5), "R4 falling recorded");

        // R2 status read-only
        wr(A_STAT, 32'h0);
        rd(A_STAT, b(3) | b(5), "R2 write zero to status");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, b(3) | b(5), "R2 write ones to status");

        // R5 clear register
        wr(A_CLR, 32'h0);
        rd(A_STAT, b(3) | b(5), "R5 zero clear no effect");
        wr(A_CLR, b(3));
        rd(A_STAT, b(5), "R5 clear one bit");
        set_pin(3, 1'b0); settle();
        rd(A_STAT, b(5), "R4 falling ignored on rising pin");

        // R11 highest pin
        set_pin(22, 1'b1); settle();
        rd(A_STAT, b(5) | b(22), "R11 pin 22");

        // R7 summary survives status clear
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R7 status cleared");
        rd_irq(A_SUMM, 32'h1, 1'b1, "R7 summary kept");

        // R8 summary clear
        wr(A_SUMM, 32'h0);
        rd(A_SUMM, 32'h1, "R8 zero write no effect");
        wr(A_SUMM, 32'h1);
        rd_irq(A_SUMM, 32'h0, 1'b0, "R8 summary cleared");

        // R9 re-assert while status pending
        set_pin(9, 1'b1); settle();
        rd_irq(A_STAT, b(9), 1'b1, "R9 setup");
        wr(A_SUMM, 32'h1);
        irq_now(1'b0, "R9 one-cycle drop");
        rd_irq(A_SUMM, 32'h1, 1'b1, "R9 re-asserted");

        // R10 edge and clear in the same cycle on pin 9
        set_pin(9, 1'b0); settle();
        @(negedge clk); pins[9] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = b(9);
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
        rd(A_STAT, b(9), "R10 set wins");
        wr(A_CLR, b(9));
        rd(A_STAT, 32'h0, "R10 plain clear");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule